// File: doc/BRIEF.md
# SPI Transfer-Group Sequencer

This block schedules buffered SPI transfers that are organised as a set of transfer groups. Each group owns a buffer window in a shared 128-entry buffer RAM. Software configures each group through one 32-bit control word. The word holds an enable, a one-shot mode, a trigger condition and a trigger source, and a start index. A group that is enabled and sees its trigger condition on its synchronised source input becomes pending. It then walks its buffer window one entry at a time.

The block does not move data itself. It presents the buffer index to be shifted next, together with the group that owns it, on a valid/ready stream to an external shift engine. One buffer entry completes on each handshake. Back-pressure follows these rules:
- While valid is high and ready is low, the index and group are held unchanged.
- Ready may be held low for any length of time.
- After every handshake, valid drops for one cycle while the next entry is chosen.

Groups compete under a fixed priority in which the lower index wins. A higher-priority group can take the stream at any entry boundary. The lower-priority group it displaces is suspended at its current index and resumes from that index later.

Top module: `spi_tg_sequencer`

## Requirements
- R1: After reset, every control word reads zero (enable, one-shot, trigger condition, source, start, done flag and current index) and `buf_valid` is low.
- R2: The control word of group X sits at byte address 0x78 + 4·X. Its fields are:
  - bit 31: enable
  - bit 30: one-shot
  - bit 29: pointer reset (always reads 0)
  - bit 28: done flag
  - bits 23:20: trigger condition
  - bits 19:16: source select
  - bits 14:8: start index
  - bits 6:0: current index

  All other bits read 0. An address that is not one of these words reads 0, and a write to it is ignored.
- R3: Each source input passes through a two-stage synchroniser before any edge or level test. The trigger condition codes are:
  - 0: never
  - 1: rising edge
  - 2: falling edge
  - 3: either edge
  - 4: high level
  - 5: low level
  - 7: always

  Every other code means never.
- R4: An enabled group that is not already pending becomes pending on its trigger. A trigger that arrives while the group is pending is ignored. A stream entry is only started for a group that was enabled in the cycle it was chosen.
- R5: A group walks its window from its current index. The window ends one entry before the start index of the nearest enabled group with a higher index. If no such group is enabled, the window ends at entry 127.
- R6: At each entry boundary, the pending group with the lowest index is chosen. A suspended group resumes at the index where it stopped.
- R7: While `buf_valid` is high and `buf_ready` is low, `buf_valid`, `buf_ptr` and `buf_group` stay stable. Each handshake completes one entry and advances that group's current index by one. `buf_valid` is low in the cycle after every handshake.
- R8: When the last entry of a window completes, the group's done flag is set and its current index is reloaded from its start index. Writing 1 to bit 28 clears the flag. If a completion and a clear fall in the same cycle, the completion wins.
- R9: When a group with one-shot set completes its window, its enable bit is cleared by the block.
- R10: With one-shot clear, each new trigger after completion starts another full walk of the window.
- R11: Clearing enable while the group's entry is on the stream lets that entry complete and advance the index by one. The rest of the window is dropped and the done flag is not set.
- R12: Writing 1 to the pointer-reset bit loads the current index from the start index carried in the same write and drops any pending walk. The write is ignored while that group's entry is on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control word write strobe |
| reg_addr | input | 8 | Byte address of the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| trig_src | input | 16 | Asynchronous trigger source inputs |
| buf_valid | output | 1 | A buffer entry is offered to the shift engine |
| buf_ready | input | 1 | The shift engine accepts the offered entry |
| buf_ptr | output | 7 | Buffer index of the offered entry |
| buf_group | output | 4 | Group that owns the offered entry |

## Verification
The hardest case to reach from the ports is preemption at an entry boundary. It needs a lower-priority group suspended in mid-window while a higher-priority group runs, followed by the resumption at the right index. The stimulus sets this up in four steps:
1. Hold `buf_ready` low so that an entry of group 2 is parked on the stream.
2. Raise the source of group 1 and give it time to become pending.
3. Release `buf_ready`.
4. Check that the scoreboard order is: the parked entry, all of group 1's window, then the rest of group 2 starting from the following index.

Disabling a group mid-transfer uses the same parking technique. The write lands while the group's entry is held on the stream.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

  localparam int PTR_W = 7;
  localparam int SRC_W = 4;
  localparam int EVT_W = 4;
  localparam int N_SRC = 1 << SRC_W;

  localparam int B_ENA   = 31;
  localparam int B_ONCE  = 30;
  localparam int B_PRST  = 29;
  localparam int B_DONE  = 28;
  localparam int B_EVT_L = 20;
  localparam int B_SRC_L = 16;
  localparam int B_STA_L = 8;

  typedef enum logic [EVT_W-1:0] {
    EV_NEVER  = 4'd0,
    EV_RISE   = 4'd1,
    EV_FALL   = 4'd2,
    EV_ANY    = 4'd3,
    EV_HIGH   = 4'd4,
    EV_LOW    = 4'd5,
    EV_ALWAYS = 4'd7
  } evt_e;

  typedef struct packed {
    logic             ena;
    logic             once;
    logic [EVT_W-1:0] evt;
    logic [SRC_W-1:0] src;
    logic [PTR_W-1:0] start;
  } tg_cfg_t;

endpackage

// File: rtl/spi_tg_trig_sync.sv
module spi_tg_trig_sync #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_SRC-1:0] lvl,
  output logic [N_SRC-1:0] rise,
  output logic [N_SRC-1:0] fall
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], src_in[i]};
    end
    assign lvl[i]  = sh[1];
    assign rise[i] = sh[1] & ~sh[2];
    assign fall[i] = ~sh[1] & sh[2];
  end
endmodule

// File: rtl/spi_tg_evt_match.sv
module spi_tg_evt_match
  import spi_tg_pkg::*;
(
  input  logic [EVT_W-1:0] evt,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [N_SRC-1:0] lvl,
  input  logic [N_SRC-1:0] rise,
  input  logic [N_SRC-1:0] fall,
  output logic             hit
);
  always_comb begin
    case (evt)
      EV_RISE:   hit = rise[src_sel];
      EV_FALL:   hit = fall[src_sel];
      EV_ANY:    hit = rise[src_sel] | fall[src_sel];
      EV_HIGH:   hit = lvl[src_sel];
      EV_LOW:    hit = ~lvl[src_sel];
      EV_ALWAYS: hit = 1'b1;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_tg_arbiter.sv
module spi_tg_arbiter #(
  parameter int NG = 16,
  localparam int IW = $clog2(NG)
) (
  input  logic [NG-1:0] req,
  output logic [IW-1:0] grant,
  output logic          any
);
  always_comb begin
    grant = '0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (req[i]) grant = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/spi_tg_bound.sv
module spi_tg_bound #(
  parameter int NG = 16,
  parameter int PW = 7,
  localparam int IW = $clog2(NG)
) (
  input  logic [NG-1:0]         en,
  input  logic [NG-1:0][PW-1:0] start,
  input  logic [IW-1:0]         idx,
  output logic [PW:0]           bound
);
  always_comb begin
    bound = {1'b1, {PW{1'b0}}};
    for (int j = NG - 1; j >= 0; j--) begin
      if (j > int'(idx) && en[j]) bound = {1'b0, start[j]};
    end
  end
endmodule

// File: rtl/spi_tg_sequencer.sv
module spi_tg_sequencer
  import spi_tg_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 8'h78,
  localparam int IW = $clog2(NUM_GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_SRC-1:0]  trig_src,
  output logic              buf_valid,
  input  logic              buf_ready,
  output logic [PTR_W-1:0]  buf_ptr,
  output logic [IW-1:0]     buf_group
);
  localparam int NG = NUM_GROUPS;
  localparam int PW = PTR_W;

  tg_cfg_t          cfg_q  [NG];
  logic [PW-1:0]    cur_q  [NG];
  logic [NG-1:0]    done_q;
  logic [NG-1:0]    pend_q;
  logic             valid_q;
  logic [IW-1:0]    act_q;

  logic [N_SRC-1:0] s_lvl, s_rise, s_fall;
  logic [NG-1:0]    hit;
  logic [NG-1:0]    en_vec, once_vec;
  logic [NG-1:0][PW-1:0] start_vec;

  spi_tg_trig_sync #(.N_SRC(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_in(trig_src),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    spi_tg_evt_match u_match (
      .evt(cfg_q[g].evt), .src_sel(cfg_q[g].src),
      .lvl(s_lvl), .rise(s_rise), .fall(s_fall), .hit(hit[g])
    );
    assign en_vec[g]    = cfg_q[g].ena;
    assign once_vec[g]  = cfg_q[g].once;
    assign start_vec[g] = cfg_q[g].start;
  end

  // register decode
  logic [ADDR_W-1:0] off;
  logic              addr_ok;
  logic [IW-1:0]     sel_idx;
  logic              wr_hit;
  tg_cfg_t           wcfg;
  logic              unused_wbits;

  assign off     = reg_addr - REG_BASE;
  assign addr_ok = (reg_addr >= REG_BASE) &&
                   (off[ADDR_W-1:2] < (ADDR_W-2)'(NG)) &&
                   (off[1:0] == 2'b00);
  assign sel_idx = off[IW+1:2];
  assign wr_hit  = reg_we && addr_ok;
  assign wcfg    = '{ena:   reg_wdata[B_ENA],
                     once:  reg_wdata[B_ONCE],
                     evt:   reg_wdata[B_EVT_L +: EVT_W],
                     src:   reg_wdata[B_SRC_L +: SRC_W],
                     start: reg_wdata[B_STA_L +: PW]};
  assign unused_wbits = ^{reg_wdata[27:24], reg_wdata[15], reg_wdata[7:0]};

  always_comb begin
    reg_rdata = '0;
    if (addr_ok) begin
      reg_rdata = {cfg_q[sel_idx].ena, cfg_q[sel_idx].once, 1'b0,
                   done_q[sel_idx], 4'b0000,
                   cfg_q[sel_idx].evt, cfg_q[sel_idx].src,
                   1'b0, cfg_q[sel_idx].start,
                   1'b0, cur_q[sel_idx]};
    end
  end

  // arbitration and window end
  logic [IW-1:0] grant;
  logic          any_req;
  logic [PW:0]   bound;

  spi_tg_arbiter #(.NG(NG)) u_arb (
    .req(pend_q & en_vec), .grant(grant), .any(any_req)
  );

  spi_tg_bound #(.NG(NG), .PW(PW)) u_bound (
    .en(en_vec), .start(start_vec), .idx(act_q), .bound(bound)
  );

  logic          hs;
  logic          act_last;
  logic          act_fin;
  logic [PW-1:0] act_cur;

  assign act_cur  = cur_q[act_q];
  assign hs       = valid_q && buf_ready;
  assign act_last = (({1'b0, act_cur} + (PW+1)'(1)) == bound) || (act_cur == '1);
  assign act_fin  = hs && act_last && pend_q[act_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        cfg_q[g] <= '0;
        cur_q[g] <= '0;
      end
      done_q  <= '0;
      pend_q  <= '0;
      valid_q <= 1'b0;
      act_q   <= '0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (cfg_q[g].ena && hit[g] && !pend_q[g]) pend_q[g] <= 1'b1;
        if (wr_hit && sel_idx == IW'(g)) begin
          cfg_q[g] <= wcfg;
          if (reg_wdata[B_DONE]) done_q[g] <= 1'b0;
          if (!reg_wdata[B_ENA]) pend_q[g] <= 1'b0;
          if (reg_wdata[B_PRST] && !(valid_q && act_q == IW'(g))) begin
            cur_q[g]  <= wcfg.start;
            pend_q[g] <= 1'b0;
          end
        end
        if (hs && act_q == IW'(g)) begin
          cur_q[g] <= act_last ? cfg_q[g].start : cur_q[g] + PW'(1);
          if (act_fin) begin
            done_q[g] <= 1'b1;
            pend_q[g] <= 1'b0;
            if (cfg_q[g].once) cfg_q[g].ena <= 1'b0;
          end
        end
      end
      if (hs) begin
        valid_q <= 1'b0;
      end else if (!valid_q && any_req) begin
        valid_q <= 1'b1;
        act_q   <= grant;
      end
    end
  end

  assign buf_valid = valid_q;
  assign buf_ptr   = act_cur;
  assign buf_group = act_q;

endmodule

// File: rtl/spi_tg_checks.sv
module spi_tg_checks #(
  parameter int NG = 16,
  parameter int PW = 7,
  localparam int IW = $clog2(NG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          buf_valid,
  input logic          buf_ready,
  input logic [PW-1:0] buf_ptr,
  input logic [IW-1:0] buf_group,
  input logic [NG-1:0] grp_en,
  input logic [NG-1:0] grp_once,
  input logic          fin,
  input logic [IW-1:0] fin_idx
);
  logic [NG-1:0] en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= '0;
    else        en_d <= grp_en;
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid); // R7
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> $stable(buf_ptr) && $stable(buf_group)); // R7
  AST_GAP_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && buf_ready |=> !buf_valid); // R7
  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fin && grp_once[fin_idx] |=> !grp_en[$past(fin_idx)]); // R9
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> en_d[buf_group]); // R4
endmodule

bind spi_tg_sequencer spi_tg_checks #(.NG(NUM_GROUPS), .PW(spi_tg_pkg::PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .buf_valid(buf_valid), .buf_ready(buf_ready),
  .buf_ptr(buf_ptr), .buf_group(buf_group), .grp_en(en_vec),
  .grp_once(once_vec), .fin(act_fin), .fin_idx(act_q)
);

// File: tb/spi_tg_sequencer_tb.sv
module spi_tg_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] trig_src = '0;
  logic        buf_valid;
  logic        buf_ready = 1'b1;
  logic [6:0]  buf_ptr;
  logic [3:0]  buf_group;

  int checks = 0;
  int fails  = 0;
  logic [10:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_tg_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_src(trig_src),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_ptr(buf_ptr),
    .buf_group(buf_group)
  );

  function automatic logic [31:0] mk(input logic en, input logic once, input logic prst,
                                     input logic clr, input logic [3:0] evt,
                                     input logic [3:0] src, input logic [6:0] start);
    return {en, once, prst, clr, 4'b0, evt, src, 1'b0, start, 8'b0};
  endfunction

  function automatic logic [31:0] rv(input logic en, input logic once, input logic done,
                                     input logic [3:0] evt, input logic [3:0] src,
                                     input logic [6:0] start, input logic [6:0] cur);
    return {en, once, 1'b0, done, 4'b0, evt, src, 1'b0, start, 1'b0, cur};
  endfunction

  task automatic wr_reg(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h78 + 8'(idx * 4); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_addr(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #2;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %h actual %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_reg(input int idx, input logic [31:0] exp, input string req);
    chk_addr(8'h78 + 8'(idx * 4), exp, req);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic push_range(input int g, input int lo, input int hi);
    for (int p = lo; p <= hi; p++) exp_q.push_back({4'(g), 7'(p)});
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    trig_src[i] = v;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || buf_valid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || buf_valid) begin
      fails++;
      $display("FAIL %s drain: actual %0d items left expected 0", req, exp_q.size());
    end
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!buf_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    #2;
  endtask

  // monitor: compares every handshake against the scoreboard
  initial begin
    logic [10:0] e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && buf_valid && buf_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected entry: actual g%0d p%0d expected none",
                   buf_group, buf_ptr);
        end else begin
          e = exp_q.pop_front();
          if ({buf_group, buf_ptr} !== e) begin
            fails++;
            $display("FAIL R5/R6 entry: actual g%0d p%0d expected g%0d p%0d",
                     buf_group, buf_ptr, e[10:7], e[6:0]);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk_bit(buf_valid, 1'b0, "R1 valid after reset");
    chk_reg(0, '0, "R1");
    chk_reg(15, '0, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: group 2 enabled but never triggers; group 1 rising on source 2
    wr_reg(2, mk(1, 0, 1, 0, 4'd0, 4'd0, 7'd10));
    wr_reg(1, mk(1, 0, 1, 0, 4'd1, 4'd2, 7'd4));
    chk_reg(1, rv(1, 0, 0, 4'd1, 4'd2, 7'd4, 7'd4), "R2 R12 field layout");
    chk_addr(8'h74, '0, "R2 out of range");

    // R3 rising edge, R5 window 4..9, R8 done and reload
    push_range(1, 4, 9);
    set_src(2, 1'b1);
    drain("R5");
    chk_reg(1, rv(1, 0, 1, 4'd1, 4'd2, 7'd4, 7'd4), "R8 done set, index reloaded");

    // R3 falling edge ignored under rising code
    set_src(2, 1'b0);
    drain("R3 fall ignored");
    chk_bit(buf_valid, 1'b0, "R3 no entry on falling edge");

    // R10 retrigger
    push_range(1, 4, 9);
    set_src(2, 1'b1);
    drain("R10");

    // R3 falling-edge code
    wr_reg(1, mk(1, 0, 0, 0, 4'd2, 4'd2, 7'd4));
    push_range(1, 4, 9);
    set_src(2, 1'b0);
    drain("R3 falling code");

    // R8 clear done
    wr_reg(1, mk(1, 0, 0, 1, 4'd2, 4'd2, 7'd4));
    chk_reg(1, rv(1, 0, 0, 4'd2, 4'd2, 7'd4, 7'd4), "R8 done cleared");

    // R9 one-shot with always code, window to 127
    push_range(3, 120, 127);
    wr_reg(3, mk(1, 1, 1, 0, 4'd7, 4'd0, 7'd120));
    drain("R9");
    chk_reg(3, rv(0, 1, 1, 4'd7, 4'd0, 7'd120, 7'd120), "R9 enable cleared");

    // R6 preemption at entry boundary
    buf_ready = 1'b0;
    wr_reg(2, mk(1, 0, 1, 0, 4'd1, 4'd4, 7'd10));
    set_src(4, 1'b1);
    wait_valid();
    chk_bit(buf_valid && buf_group == 4'd2 && buf_ptr == 7'd10, 1'b1, "R7 parked entry");
    repeat (5) @(negedge clk);
    #2;
    chk_bit(buf_valid && buf_group == 4'd2 && buf_ptr == 7'd10, 1'b1, "R7 held under back-pressure");
    wr_reg(1, mk(1, 0, 1, 0, 4'd1, 4'd2, 7'd4));
    set_src(2, 1'b1);
    repeat (10) @(negedge clk);
    exp_q.push_back({4'd2, 7'd10});
    push_range(1, 4, 9);
    push_range(2, 11, 127);
    @(negedge clk);
    buf_ready = 1'b1;
    drain("R6");
    chk_reg(2, rv(1, 0, 1, 4'd1, 4'd4, 7'd10, 7'd10), "R6 resumed window done");

    // R11 disable mid-transfer
    @(negedge clk);
    buf_ready = 1'b0;
    set_src(4, 1'b0);
    repeat (4) @(negedge clk);
    set_src(4, 1'b1);
    wait_valid();
    wr_reg(2, mk(0, 0, 0, 1, 4'd1, 4'd4, 7'd10));
    exp_q.push_back({4'd2, 7'd10});
    @(negedge clk);
    buf_ready = 1'b1;
    drain("R11");
    chk_reg(2, rv(0, 0, 0, 4'd1, 4'd4, 7'd10, 7'd11), "R11 one entry, no done");

    // R12 pointer reset
    wr_reg(2, mk(0, 0, 1, 0, 4'd1, 4'd4, 7'd10));
    chk_reg(2, rv(0, 0, 0, 4'd1, 4'd4, 7'd10, 7'd10), "R12 index reloaded");

    // R3 low level, one-shot, window bounded by group 1 start
    push_range(0, 0, 3);
    wr_reg(0, mk(1, 1, 1, 0, 4'd5, 4'd5, 7'd0));
    drain("R3 low level");
    chk_reg(0, rv(0, 1, 1, 4'd5, 4'd5, 7'd0, 7'd0), "R9 group 0 disabled");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule